// File: doc/BRIEF.md
# Dual-Mode Word Serializer/Deserializer Core

This block models the digital transmit and receive data paths of a gigabit serial link endpoint. On the transmit side it captures 10-bit coded words from a parallel port and shifts each word onto a single serial line, one bit per tick of a bit clock that runs at ten times the word clock. The parallel port works in one of two shapes. In the wide shape a whole word is taken on each rising edge of the word clock. In the narrow shape two 5-bit halves are taken on the two edges of one word-clock period.

The receive side takes a serial stream whose word boundary is fixed from the first word boundary after reset. It rebuilds 10-bit words and presents them in the selected shape, with a one-cycle strobe for each item it presents. A loopback control feeds the transmit stream straight into the receiver and releases the serial output. Output enables take the place of the high-impedance states. They are deasserted while reset is active and force the gated data to zero.

Top module: `dualmode_serdes`

## Requirements
- R1: `halfMode` low selects the wide 10-bit parallel shape and `halfMode` high selects the narrow 5-bit double-edge shape. The mode is held constant outside reset.
- R2: In wide mode, all ten `txData` bits are captured on the rising edge of `refClk`, and each captured word appears unchanged at the receiver.
- R3: In narrow mode, `txData[4:0]` captured on a rising edge of `refClk` forms word bits 4:0, and `txData[4:0]` captured on the following falling edge forms word bits 9:5. `txData[9:5]` has no effect on the word.
- R4: `txSerial` carries each word with bit 0 first and bit 9 last, one bit per `bitClk` cycle, and the words follow back to back.
- R5: In wide mode, each rebuilt word appears on `rxData` with bit 0 being the first serial bit received, marked by a one-cycle `rxStrobe`. Consecutive strobes are exactly 10 `bitClk` cycles apart.
- R6: In narrow mode, each rebuilt word is presented as two strobed items on `rxData[4:0]`: first word bits 4:0, then word bits 9:5 exactly 5 `bitClk` cycles later. `rxData[9:5]` is 0 on every strobe.
- R7: With `loopEn` high, `txSerialOe` is low, `txSerial` is 0, the receiver takes the internal transmit stream, and `rxSerial` has no effect.
- R8: With `loopEn` low and reset released, `txSerialOe` is high and the receiver takes its bits from `rxSerial`.
- R9: While `rstN` is low, `txSerialOe` and `rxOe` are low, and `txSerial`, `rxData` and `rxStrobe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Word clock; both edges are used in narrow mode |
| bitClk | input | 1 | Serial bit clock at ten times the word rate |
| rstN | input | 1 | Asynchronous active-low reset |
| halfMode | input | 1 | 0: wide 10-bit port, 1: narrow 5-bit double-edge port |
| loopEn | input | 1 | Routes the transmit stream into the receiver and releases the serial output |
| txData | input | 10 | Parallel transmit word or half-word |
| rxSerial | input | 1 | External serial receive bit |
| txSerial | output | 1 | Serial transmit bit, 0 when not enabled |
| txSerialOe | output | 1 | Serial output enable |
| rxData | output | 10 | Rebuilt word or half-word |
| rxStrobe | output | 1 | One-cycle marker for each item on rxData |
| rxOe | output | 1 | Enable of the parallel receive outputs |

## Verification
Two events can land on the same `bitClk` edge. A word boundary loads the transmit shifter with a new word, and on that same edge the receiver takes in the last bit of the previous word and emits it. Narrow mode adds an edge where the upper half of the previous word is presented while the next word is already being gathered. The bench provokes both with unbroken back-to-back word streams in each mode, with and without loopback. It judges the result by matching the full received word sequence, and the exact 10- and 5-cycle strobe spacing, against the words it drove.

// File: rtl/serdes_pkg.sv
package serdes_pkg;
  localparam int WORD_W_DEF = 10;

  typedef struct packed {
    logic loadTx;    // load the transmit shifter with a new word
    logic capBit;    // receiver samples one serial bit
    logic wordDone;  // the sampled bit completes a word
    logic emitHi;    // mid-frame point for the upper half in narrow mode
  } serdesCtl_t;
endpackage

// File: rtl/serdes_ctrl.sv
module serdes_ctrl
  import serdes_pkg::*;
#(
  parameter int WORD_W = WORD_W_DEF
) (
  input  logic       bitClk,
  input  logic       rstN,
  input  logic       refClk,
  output serdesCtl_t ctl
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] HALF_IDX = CNT_W'(WORD_W / 2 - 1);

  logic refSamp, refPrev, started;
  logic [CNT_W-1:0] bitIdx;
  logic riseSeen;

  assign riseSeen = refSamp & ~refPrev;

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      refSamp <= 1'b0;
      refPrev <= 1'b0;
      started <= 1'b0;
      bitIdx  <= '0;
    end else begin
      refSamp <= refClk;
      refPrev <= refSamp;
      if (riseSeen) started <= 1'b1;
      if (riseSeen) bitIdx <= '0;
      else if (bitIdx != LAST_IDX) bitIdx <= bitIdx + 1'b1;
    end
  end

  always_comb begin
    ctl.loadTx   = riseSeen;
    ctl.capBit   = started;
    ctl.wordDone = started && (bitIdx == LAST_IDX);
    ctl.emitHi   = started && (bitIdx == HALF_IDX);
  end
endmodule

// File: rtl/serdes_dp.sv
module serdes_dp
  import serdes_pkg::*;
#(
  parameter int WORD_W = WORD_W_DEF
) (
  input  logic              refClk,
  input  logic              bitClk,
  input  logic              rstN,
  input  logic              halfMode,
  input  logic              loopEn,
  input  logic [WORD_W-1:0] txData,
  input  logic              rxSerial,
  input  serdesCtl_t        ctl,
  output logic              lineBit,
  output logic [WORD_W-1:0] rxWordQ,
  output logic              rxStrobeQ
);
  localparam int HALF_W = WORD_W / 2;

  logic [HALF_W-1:0] loHalf, hiHalf, hiHold;
  logic [WORD_W-1:0] txWord, txShift, rxShift, rxWordNext;
  logic pendHi, rxBit;

  // word-clock capture: wide word on rise, or halves on rise and fall
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      loHalf <= '0;
      txWord <= '0;
    end else begin
      loHalf <= txData[HALF_W-1:0];
      txWord <= halfMode ? {hiHalf, loHalf} : txData;
    end
  end

  always_ff @(negedge refClk or negedge rstN) begin
    if (!rstN) hiHalf <= '0;
    else       hiHalf <= txData[HALF_W-1:0];
  end

  // transmit shifter, bit 0 leaves first
  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN)           txShift <= '0;
    else if (ctl.loadTx) txShift <= txWord;
    else                 txShift <= {1'b0, txShift[WORD_W-1:1]};
  end

  assign lineBit    = txShift[0];
  assign rxBit      = loopEn ? lineBit : rxSerial;
  assign rxWordNext = {rxBit, rxShift[WORD_W-1:1]};

  // receive gatherer and output presentation
  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      rxShift   <= '0;
      rxWordQ   <= '0;
      rxStrobeQ <= 1'b0;
      hiHold    <= '0;
      pendHi    <= 1'b0;
    end else begin
      rxStrobeQ <= 1'b0;
      if (ctl.capBit) rxShift <= rxWordNext;
      if (ctl.wordDone) begin
        rxStrobeQ <= 1'b1;
        if (halfMode) begin
          rxWordQ <= {{(WORD_W-HALF_W){1'b0}}, rxWordNext[HALF_W-1:0]};
          hiHold  <= rxWordNext[WORD_W-1:HALF_W];
          pendHi  <= 1'b1;
        end else begin
          rxWordQ <= rxWordNext;
        end
      end else if (ctl.emitHi && pendHi) begin
        rxStrobeQ <= 1'b1;
        rxWordQ   <= {{(WORD_W-HALF_W){1'b0}}, hiHold};
        pendHi    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dualmode_serdes.sv
module dualmode_serdes
  import serdes_pkg::*;
#(
  parameter int WORD_W = WORD_W_DEF
) (
  input  logic              refClk,
  input  logic              bitClk,
  input  logic              rstN,
  input  logic              halfMode,
  input  logic              loopEn,
  input  logic [WORD_W-1:0] txData,
  input  logic              rxSerial,
  output logic              txSerial,
  output logic              txSerialOe,
  output logic [WORD_W-1:0] rxData,
  output logic              rxStrobe,
  output logic              rxOe
);
  serdesCtl_t ctl;
  logic lineBit, rxStrobeQ;
  logic [WORD_W-1:0] rxWordQ;

  serdes_ctrl #(.WORD_W(WORD_W)) uCtrl (
    .bitClk(bitClk), .rstN(rstN), .refClk(refClk), .ctl(ctl)
  );

  serdes_dp #(.WORD_W(WORD_W)) uDp (
    .refClk(refClk), .bitClk(bitClk), .rstN(rstN), .halfMode(halfMode),
    .loopEn(loopEn), .txData(txData), .rxSerial(rxSerial), .ctl(ctl),
    .lineBit(lineBit), .rxWordQ(rxWordQ), .rxStrobeQ(rxStrobeQ)
  );

  assign txSerialOe = rstN & ~loopEn;
  assign txSerial   = txSerialOe & lineBit;
  assign rxOe       = rstN;
  assign rxData     = rxOe ? rxWordQ : '0;
  assign rxStrobe   = rxOe & rxStrobeQ;
endmodule

// File: rtl/serdes_chk.sv
module serdes_chk #(
  parameter int WORD_W = 10
) (
  input logic              bitClk,
  input logic              rstN,
  input logic              halfMode,
  input logic              loopEn,
  input logic              txSerial,
  input logic              txSerialOe,
  input logic [WORD_W-1:0] rxData,
  input logic              rxStrobe,
  input logic              rxOe
);
  localparam int HALF_W = WORD_W / 2;
  logic [7:0] gapCnt;
  logic seenOne;

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      gapCnt  <= '0;
      seenOne <= 1'b0;
    end else if (rxStrobe) begin
      gapCnt  <= '0;
      seenOne <= 1'b1;
    end else if (gapCnt != 8'hFF) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  a_r7_loop_releases: assert property (@(posedge bitClk) disable iff (!rstN)
    loopEn |-> (!txSerialOe && !txSerial));

  a_r8_drive_when_no_loop: assert property (@(posedge bitClk) disable iff (!rstN)
    !loopEn |-> txSerialOe);

  a_r6_upper_low: assert property (@(posedge bitClk) disable iff (!rstN)
    (halfMode && rxStrobe) |-> (rxData[WORD_W-1:HALF_W] == '0));

  a_r5_word_spacing: assert property (@(posedge bitClk) disable iff (!rstN)
    (!halfMode && rxStrobe && seenOne) |-> (gapCnt == 8'(WORD_W - 1)));

  a_r6_half_spacing: assert property (@(posedge bitClk) disable iff (!rstN)
    (halfMode && rxStrobe && seenOne) |-> (gapCnt == 8'(HALF_W - 1)));

  always @(negedge bitClk) begin
    if (!rstN) begin
      a_r9_reset_quiet: assert (!txSerialOe && !rxOe && !txSerial && !rxStrobe && rxData == '0);
    end
  end
endmodule

bind dualmode_serdes serdes_chk #(.WORD_W(WORD_W)) uChk (
  .bitClk(bitClk), .rstN(rstN), .halfMode(halfMode), .loopEn(loopEn),
  .txSerial(txSerial), .txSerialOe(txSerialOe), .rxData(rxData),
  .rxStrobe(rxStrobe), .rxOe(rxOe)
);

// File: tb/tb_dualmode_serdes.sv
module tb_dualmode_serdes;
  localparam int W = 10;
  localparam int NW = 14;

  logic refClk = 1'b0, bitClk = 1'b0, rstN = 1'b0;
  logic halfMode = 1'b0, loopEn = 1'b0, junkBit = 1'b0;
  logic [W-1:0] txData = '0;
  logic rxSerial, txSerial, txSerialOe, rxStrobe, rxOe;
  logic [W-1:0] rxData;

  int nChecks = 0, nFails = 0, tick = 0;
  logic capturing = 1'b0;
  logic [W-1:0] sentW [0:31];
  logic [W-1:0] pieceV [0:127];
  int pieceT [0:127];
  int nPiece = 0;
  logic serBits [0:2047];
  int nBits = 0;

  assign rxSerial = loopEn ? junkBit : txSerial;

  dualmode_serdes dut (
    .refClk(refClk), .bitClk(bitClk), .rstN(rstN), .halfMode(halfMode),
    .loopEn(loopEn), .txData(txData), .rxSerial(rxSerial), .txSerial(txSerial),
    .txSerialOe(txSerialOe), .rxData(rxData), .rxStrobe(rxStrobe), .rxOe(rxOe)
  );

  always #5 bitClk = ~bitClk;
  initial begin #2; forever #50 refClk = ~refClk; end

  always @(posedge bitClk) tick <= tick + 1;
  always @(posedge bitClk) junkBit <= 1'($urandom);

  always @(negedge bitClk) begin
    if (capturing && rstN) begin
      if (rxStrobe && nPiece < 128) begin
        pieceV[nPiece] = rxData;
        pieceT[nPiece] = tick;
        nPiece++;
      end
      if (txSerialOe && nBits < 2048) begin
        serBits[nBits] = txSerial;
        nBits++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pick_word(input int i);
    if (i == 0) return 10'h2B5;
    if (i == 1) return 10'h3FF;
    if (i == 2) return 10'h000;
    if (i == 3) return 10'h001;
    if (i == 4) return 10'h200;
    return W'($urandom);
  endfunction

  task automatic run_phase(input logic hm, input logic lp);
    logic [W-1:0] recvW [0:63];
    int nRecv = 0, off = -1, bad = 0;
    rstN = 1'b0;
    halfMode = hm;
    loopEn = lp;
    capturing = 1'b0;
    nPiece = 0;
    nBits = 0;
    repeat (3) @(negedge bitClk);
    check(!txSerialOe && !rxOe && !txSerial && !rxStrobe && rxData == '0,
          "R9 reset outputs quiet", {txSerialOe, rxOe, rxStrobe}, 0);
    rstN = 1'b1;
    capturing = 1'b1;
    for (int i = 0; i < NW; i++) sentW[i] = pick_word(i);
    for (int i = 0; i < NW; i++) begin
      if (hm) begin
        @(negedge refClk); #20 txData = {5'($urandom), sentW[i][4:0]};
        @(posedge refClk); #20 txData = {5'($urandom), sentW[i][9:5]};
      end else begin
        @(posedge refClk); #20 txData = sentW[i];
      end
      if (i == 2) begin
        @(negedge bitClk);
        if (lp) check(!txSerialOe && !txSerial, "R7 serial released in loopback", txSerialOe, 0);
        else    check(txSerialOe, "R8 serial driven without loopback", txSerialOe, 1);
      end
    end
    repeat (60) @(negedge bitClk);
    capturing = 1'b0;

    // assemble received words from strobed items
    if (hm) begin
      for (int k = 0; k + 1 < nPiece; k += 2) begin
        if (pieceV[k][9:5] != 0 || pieceV[k+1][9:5] != 0) bad++;
        if (pieceT[k+1] - pieceT[k] != 5) bad++;
        recvW[nRecv] = {pieceV[k+1][4:0], pieceV[k][4:0]};
        nRecv++;
      end
      check(bad == 0 && nPiece >= 2, "R6 half items: upper bits low, 5-cycle gap", bad, 0);
    end else begin
      for (int k = 0; k < nPiece; k++) begin
        if (k > 0 && pieceT[k] - pieceT[k-1] != 10) bad++;
        recvW[nRecv] = pieceV[k];
        nRecv++;
      end
      check(bad == 0 && nPiece >= 2, "R5 strobes 10 cycles apart", bad, 0);
    end

    for (int k = 0; k < nRecv && off < 0; k++) if (recvW[k] == sentW[0]) off = k;
    check(off >= 0 && off <= 3, "R1 first word found at fixed offset", off, 1);
    if (off < 0) off = 0;
    for (int i = 0; i < NW; i++) begin
      logic [W-1:0] got;
      got = (off + i < nRecv) ? recvW[off + i] : 10'h3FF ^ sentW[i];
      if (hm) check(got == sentW[i], lp ? "R3 R7 narrow loopback word" : "R3 R8 narrow external word", got, sentW[i]);
      else    check(got == sentW[i], lp ? "R2 R5 R7 wide loopback word" : "R2 R5 R8 wide external word", got, sentW[i]);
    end

    // serial order: sent words LSB first, back to back on txSerial
    if (!lp) begin
      int found = -1;
      for (int o = 0; o + NW * W <= nBits && found < 0; o++) begin
        bit ok = 1;
        for (int i = 0; i < NW && ok; i++)
          for (int b = 0; b < W; b++)
            if (serBits[o + i*W + b] != sentW[i][b]) ok = 0;
        if (ok) found = o;
      end
      check(found >= 0, "R4 serial bit order bit0 first", found, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240517));
    run_phase(1'b0, 1'b1);
    run_phase(1'b1, 1'b1);
    run_phase(1'b0, 1'b0);
    run_phase(1'b1, 1'b0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #1_000_000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", tick, 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule